// File: doc/BRIEF.md
# Variable-Latency Four-Stage In-Order Pipeline

This block moves tokens through four stages in series. Every token carries an 8-bit tag and its own occupancy count (1 to 3 cycles) for each of the four stages, so one token may sit in stage 2 for three cycles while the next needs only one. A token enters through a valid/ready port. Each stage is a small state machine that holds a token for its listed count and then hands it on. A token starts a stage at the later of two moments: when it has finished the stage before, and when the token ahead of it has left this stage. Tokens never overtake one another.

A parameter selects how finished work waits. In queued mode a first-in first-out queue of `QDEPTH` entries sits between adjacent stages, so a stage can drop its finished token into the queue and take new work while the next stage is busy. When a queue is full, its feeding stage waits exactly as in blocking mode. In blocking mode there are no queues, and a finished stage keeps its token until the next stage frees up. A free-running cycle counter stamps each token as it retires.

Each stage state machine has three states. `SLOT_EMPTY` holds no token. `SLOT_COUNT` holds a token with more than one cycle left. `SLOT_READY` holds a token in its last cycle, or a finished token that is waiting to move on. The transitions are as follows. *load* goes from EMPTY to COUNT, or straight to READY when the count is 1. *tick* decrements the count and stays in COUNT. *last* goes from COUNT to READY when two cycles remain. *leave* goes from READY to EMPTY. *swap* is a leave and a load on the same edge, which stays busy with the new token. *hold* stays in READY because the next stage or the queue cannot take the token.

Top module: `vlp_pipe`

## Requirements
- R1: Every accepted token with legal counts passes stages 1 to 4 in order and retires exactly once. Tokens retire in the order they were accepted, carrying their own tag.
- R2: `in_cnt` bits [2k+1:2k] give the number of cycles the token occupies stage k+1 (k = 0..3), with legal values 1, 2 and 3. A token that is not blocked occupies each stage for exactly that many cycles.
- R3: A token starts stage k+1 in the cycle after the later of two events: the last cycle it spent in stage k, and the last cycle its predecessor spent in stage k+1.
- R4: With `QUEUED`=1, a token that has finished a stage leaves it at once when the queue ahead has room. The stage can then take its next token in the following cycle, even if the next stage is still busy.
- R5: With `QUEUED`=1, a stage whose output queue holds `QDEPTH` tokens, none of which leaves that cycle, keeps its finished token as in blocking mode.
- R6: With `QUEUED`=0, a finished token stays in its stage until the next stage can take it. While stage 1 holds such a token, `in_ready` is low.
- R7: `ret_cycle` reads 0 in the first cycle after reset and rises by 1 every cycle. Stage 1 is first occupied in cycle 1.
- R8: `ret_valid` is high for exactly one cycle per retiring token, during that token's final stage-4 cycle. In that cycle `ret_tag` is the token's tag and `ret_cycle` is the counter value.
- R9: `bad_cnt` is high while `in_valid` is high and any count field is 0. Such a token completes the handshake but is discarded: it never retires and does not change the timing of later tokens beyond its own handshake cycle.
- R10: A synchronous active-high `rst` empties all stages and queues. In the first cycle after reset, `ret_valid` is low and `in_ready` is high.
- R11: For eight tokens with counts (2,1,1,1), (1,3,2,2), (2,1,1,3), (1,2,2,2) repeated twice and fed back to back from cycle 0 in queued mode, the fourth token retires in cycle 15 and the eighth in cycle 23.
- R12: A token is accepted on a clock edge where `in_valid` and `in_ready` are both high. The cycle after that edge is the token's first stage-1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Token offered |
| in_ready | output | 1 | Stage 1 can take a token this cycle |
| in_tag | input | 8 | Tag of the offered token |
| in_cnt | input | 8 | Four 2-bit stage counts, stage 1 in the low bits |
| bad_cnt | output | 1 | Offered token has a zero count field |
| ret_valid | output | 1 | A token is in its final stage-4 cycle |
| ret_tag | output | 8 | Tag of the retiring token |
| ret_cycle | output | 16 | Free-running cycle counter |

## Verification
A stage whose remaining count is wrong, or a stage that leaves READY too early, shifts the retire cycle of its own token and of every token behind it. The shift shows on `ret_cycle` at the very next retirement. A queue that loses or duplicates an entry shows up as a wrong or missing `ret_tag` when that slot reaches stage 4. A blocking decision that is too lax lets two tokens occupy one stage, which makes two retirements land closer together than the counts allow. A decision that is too strict delays every later retirement by at least one cycle. All of these are caught within a few cycles of the fault, because each retirement is compared to an independently computed start-time schedule.

// File: rtl/vlp_pkg.sv
package vlp_pkg;
    localparam int NSTG  = 4;
    localparam int CNT_W = 2;
    localparam int TAG_W = 8;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic [TAG_W-1:0]    tag;
        cnt_t [NSTG-1:0]     cnt;
    } tok_t;

    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_COUNT = 2'd1,
        SLOT_READY = 2'd2
    } slot_e;
endpackage

// File: rtl/vlp_stage.sv
module vlp_stage
    import vlp_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  leave,
    input  tok_t  ld_tok,
    output slot_e state,
    output tok_t  tok
);
    slot_e state_q, state_d;
    tok_t  tok_q, tok_d;
    cnt_t  rem_q, rem_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SLOT_EMPTY;
            tok_q   <= '0;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            tok_q   <= tok_d;
            rem_q   <= rem_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        tok_d   = tok_q;
        rem_d   = rem_q;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (load) begin
                    tok_d   = ld_tok;
                    rem_d   = ld_tok.cnt[IDX];
                    state_d = (ld_tok.cnt[IDX] <= 2'd1) ? SLOT_READY : SLOT_COUNT;
                end
            end
            SLOT_COUNT: begin
                rem_d = rem_q - 2'd1;
                if (rem_q == 2'd2) state_d = SLOT_READY;
            end
            SLOT_READY: begin
                if (leave) begin
                    if (load) begin
                        tok_d   = ld_tok;
                        rem_d   = ld_tok.cnt[IDX];
                        state_d = (ld_tok.cnt[IDX] <= 2'd1) ? SLOT_READY : SLOT_COUNT;
                    end else begin
                        state_d = SLOT_EMPTY;
                    end
                end
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        state = state_q;
        tok   = tok_q;
    end
endmodule

// File: rtl/vlp_queue.sv
module vlp_queue
    import vlp_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic pop,
    input  tok_t wdata,
    output tok_t head,
    output logic empty,
    output logic full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    tok_t           mem [DEPTH];
    logic [AW-1:0]  rd_q, wr_q;
    logic [AW:0]    n_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
            wr_q <= '0;
            n_q  <= '0;
        end else begin
            if (push) wr_q <= bump(wr_q);
            if (pop)  rd_q <= bump(rd_q);
            unique case ({push, pop})
                2'b10:   n_q <= n_q + (AW+1)'(1);
                2'b01:   n_q <= n_q - (AW+1)'(1);
                default: n_q <= n_q;
            endcase
        end
    end

    always_comb begin
        head  = mem[rd_q];
        empty = (n_q == '0);
        full  = (n_q == (AW+1)'(DEPTH));
    end
endmodule

// File: rtl/vlp_pipe.sv
module vlp_pipe
    import vlp_pkg::*;
#(
    parameter int QUEUED = 1,
    parameter int QDEPTH = 4,
    parameter int CYC_W  = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [TAG_W-1:0]       in_tag,
    input  logic [NSTG*CNT_W-1:0]  in_cnt,
    output logic                   bad_cnt,
    output logic                   ret_valid,
    output logic [TAG_W-1:0]       ret_tag,
    output logic [CYC_W-1:0]       ret_cycle
);
    localparam int LAST = NSTG - 1;
    localparam int NQ   = NSTG - 1;

    slot_e              st     [NSTG];
    tok_t               tk     [NSTG];
    tok_t               ld_tok [NSTG];
    logic [NSTG-1:0]    ld, dep, done, free;
    logic [NQ-1:0]      q_push, q_pop, q_empty, q_full;
    tok_t               q_head [NQ];
    tok_t               in_tok;
    logic               zero_fld;
    logic [CYC_W-1:0]   cyc_q;

    // signals observed by the bound checker
    logic [NSTG-1:0][TAG_W-1:0] tag_v;
    logic                       s1_idle;

    always_comb begin
        in_tok.tag = in_tag;
        in_tok.cnt = in_cnt;
        zero_fld   = 1'b0;
        for (int k = 0; k < NSTG; k++) begin
            if (in_cnt[k*CNT_W +: CNT_W] == '0) zero_fld = 1'b1;
        end
        bad_cnt = in_valid && zero_fld;
    end

    generate
        for (genvar g = 0; g < NSTG; g++) begin : g_stage
            vlp_stage #(.IDX(g)) u_stg (
                .clk    (clk),
                .rst    (rst),
                .load   (ld[g]),
                .leave  (dep[g]),
                .ld_tok (ld_tok[g]),
                .state  (st[g]),
                .tok    (tk[g])
            );
        end
        if (QUEUED != 0) begin : g_queued
            for (genvar q = 0; q < NQ; q++) begin : g_q
                vlp_queue #(.DEPTH(QDEPTH)) u_q (
                    .clk   (clk),
                    .rst   (rst),
                    .push  (q_push[q]),
                    .pop   (q_pop[q]),
                    .wdata (tk[q]),
                    .head  (q_head[q]),
                    .empty (q_empty[q]),
                    .full  (q_full[q])
                );
            end
        end else begin : g_direct
            for (genvar q = 0; q < NQ; q++) begin : g_tie
                assign q_head[q] = '0;
            end
            assign q_empty = '1;
            assign q_full  = '1;
        end
    endgenerate

    // hand-off network, resolved from the last stage backwards
    always_comb begin
        ld     = '0;
        dep    = '0;
        free   = '0;
        q_push = '0;
        q_pop  = '0;
        for (int s = 0; s < NSTG; s++) begin
            done[s]   = (st[s] == SLOT_READY);
            ld_tok[s] = '0;
        end
        dep[LAST]  = done[LAST];
        free[LAST] = (st[LAST] == SLOT_EMPTY) || dep[LAST];
        for (int s = NSTG - 2; s >= 0; s--) begin
            if (QUEUED != 0) begin
                q_pop[s]    = free[s+1] && !q_empty[s];
                dep[s]      = done[s] && (!q_full[s] || q_pop[s]);
                ld[s+1]     = free[s+1] && (!q_empty[s] || dep[s]);
                ld_tok[s+1] = q_empty[s] ? tk[s] : q_head[s];
                q_push[s]   = dep[s] && !(q_empty[s] && free[s+1]);
            end else begin
                dep[s]      = done[s] && free[s+1];
                ld[s+1]     = dep[s];
                ld_tok[s+1] = tk[s];
            end
            free[s] = (st[s] == SLOT_EMPTY) || dep[s];
        end
        in_ready  = free[0] && !rst;
        ld[0]     = in_valid && in_ready && !zero_fld;
        ld_tok[0] = in_tok;
    end

    always_ff @(posedge clk) begin
        if (rst) cyc_q <= '0;
        else     cyc_q <= cyc_q + CYC_W'(1);
    end

    always_comb begin
        ret_valid = done[LAST];
        ret_tag   = tk[LAST].tag;
        ret_cycle = cyc_q;
        s1_idle   = (st[0] == SLOT_EMPTY);
        for (int s = 0; s < NSTG; s++) tag_v[s] = tk[s].tag;
    end
endmodule

// File: rtl/vlp_chk.sv
module vlp_chk
    import vlp_pkg::*;
#(
    parameter int CYC_W = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       in_valid,
    input logic                       in_ready,
    input logic                       bad_cnt,
    input logic                       ret_valid,
    input logic [CYC_W-1:0]           ret_cycle,
    input logic [NSTG-1:0]            rdy_v,
    input logic [NSTG-1:0]            dep_v,
    input logic [NSTG-1:0][TAG_W-1:0] tag_v,
    input logic                       s1_idle
);
    logic             seen_q;
    logic [CYC_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (ret_valid) begin
            seen_q <= 1'b1;
            last_q <= ret_cycle;
        end
    end

    AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ret_cycle == $past(ret_cycle) + CYC_W'(1)); // R7

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ret_valid && ret_cycle == '0)); // R10

    AST_RET_ASCEND: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && seen_q) |-> ret_cycle > last_q); // R8

    AST_BAD_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && bad_cnt) |=> s1_idle); // R9

    AST_S1_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (rdy_v[0] && !dep_v[0]) |-> !in_ready); // R6

    generate
        for (genvar s = 0; s < NSTG - 1; s++) begin : g_hold
            AST_HOLD_TOKEN: assert property (@(posedge clk) disable iff (rst)
                (rdy_v[s] && !dep_v[s]) |=> (rdy_v[s] && $stable(tag_v[s]))); // R6
        end
    endgenerate
endmodule

bind vlp_pipe vlp_chk #(.CYC_W(CYC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .bad_cnt   (bad_cnt),
    .ret_valid (ret_valid),
    .ret_cycle (ret_cycle),
    .rdy_v     (done),
    .dep_v     (dep),
    .tag_v     (tag_v),
    .s1_idle   (s1_idle)
);

// File: tb/vlp_pipe_test.sv
module vlp_pipe_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAXT       = 128;
    localparam int QD         = 4;
    localparam int LIMIT      = 4000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run = 1'b0;

    int         n_tok = 0;
    int         n_good = 0;
    logic [7:0] t_tag [MAXT+1];
    logic [7:0] t_cnt [MAXT+1];
    logic [7:0] g_tag [MAXT];
    int         exp_c [2][MAXT];
    int         act_c [2][MAXT];
    int         n_chk = 0;
    int         n_fail = 0;

    int p0, p1;
    logic v0, v1, r0, r1, b0, b1, rv0, rv1;
    logic [7:0] tg0, tg1, cn0, cn1, rt0, rt1;
    logic [15:0] rc0, rc1;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign v0  = run && (p0 < n_tok);
    assign v1  = run && (p1 < n_tok);
    assign tg0 = t_tag[p0];
    assign cn0 = t_cnt[p0];
    assign tg1 = t_tag[p1];
    assign cn1 = t_cnt[p1];

    always @(posedge clk) begin
        if (rst) p0 <= 0; else if (v0 && r0) p0 <= p0 + 1;
    end
    always @(posedge clk) begin
        if (rst) p1 <= 0; else if (v1 && r1) p1 <= p1 + 1;
    end

    vlp_pipe #(.QUEUED(1), .QDEPTH(QD)) uut (
        .clk(clk), .rst(rst), .in_valid(v0), .in_ready(r0), .in_tag(tg0), .in_cnt(cn0),
        .bad_cnt(b0), .ret_valid(rv0), .ret_tag(rt0), .ret_cycle(rc0));

    vlp_pipe #(.QUEUED(0), .QDEPTH(QD)) uut_blk (
        .clk(clk), .rst(rst), .in_valid(v1), .in_ready(r1), .in_tag(tg1), .in_cnt(cn1),
        .bad_cnt(b1), .ret_valid(rv1), .ret_tag(rt1), .ret_cycle(rc1));

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [7:0] pk(input int a, input int b, input int c, input int d);
        return {d[1:0], c[1:0], b[1:0], a[1:0]};
    endfunction

    function automatic bit is_bad(input logic [7:0] c);
        return (c[1:0] == 0) || (c[3:2] == 0) || (c[5:4] == 0) || (c[7:6] == 0);
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // start-time schedule from R3..R6, R9, R12; d = queue depth, 0 = blocking
    task automatic model(input int d, input int sel);
        int st [MAXT][4];
        int dp [MAXT][4];
        int next_acc, dprev, acc, g, e, c;
        next_acc = 0; dprev = 0; g = 0;
        for (int i = 0; i < n_tok; i++) begin
            acc = mx(next_acc, dprev);
            next_acc = acc + 1;
            if (!is_bad(t_cnt[i])) begin
                st[g][0] = acc + 1;
                for (int s = 0; s < 4; s++) begin
                    c = int'(t_cnt[i][2*s +: 2]);
                    e = st[g][s] + c - 1;
                    if (s == 3) begin
                        dp[g][s] = e;
                    end else begin
                        if (d == 0) dp[g][s] = (g > 0) ? mx(e, dp[g-1][s+1]) : e;
                        else        dp[g][s] = (g >= d) ? mx(e, st[g-d][s+1] - 1) : e;
                        st[g][s+1] = (g > 0) ? mx(dp[g][s] + 1, dp[g-1][s+1] + 1) : dp[g][s] + 1;
                    end
                end
                exp_c[sel][g] = dp[g][3];
                g_tag[g] = t_tag[i];
                dprev = dp[g][0];
                g++;
            end
        end
        n_good = g;
    endtask

    task automatic run_phase(input string lq, input string lb);
        int ri0, ri1, cyc;
        model(QD, 0);
        model(0, 1);
        rst = 1'b1; run = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0; run = 1'b1;
        #1;
        chk(rv0 == 1'b0 && rv1 == 1'b0, "R10 ret_valid after reset", int'(rv0), 0);
        chk(r0 == 1'b1 && r1 == 1'b1, "R10 in_ready after reset", int'(r0), 1);
        chk(rc0 == 16'd0, "R7 counter in first cycle", int'(rc0), 0);
        ri0 = 0; ri1 = 0; cyc = 0;
        while ((ri0 < n_good || ri1 < n_good) && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
            if (v0 && is_bad(cn0)) chk(b0 == 1'b1, "R9 bad_cnt flag", int'(b0), 1);
            if (v1 && !is_bad(cn1)) chk(b1 == 1'b0, "R9 bad_cnt clear", int'(b1), 0);
            if (rv0) begin
                if (ri0 < n_good) begin
                    chk(rt0 == g_tag[ri0], {lq, " R1 tag"}, int'(rt0), int'(g_tag[ri0]));
                    chk(int'(rc0) == exp_c[0][ri0], {lq, " R3 R8 cycle"}, int'(rc0), exp_c[0][ri0]);
                    act_c[0][ri0] = int'(rc0);
                end else chk(1'b0, "R1 extra retire", ri0, n_good);
                ri0++;
            end
            if (rv1) begin
                if (ri1 < n_good) begin
                    chk(rt1 == g_tag[ri1], {lb, " R1 tag"}, int'(rt1), int'(g_tag[ri1]));
                    chk(int'(rc1) == exp_c[1][ri1], {lb, " R6 R8 cycle"}, int'(rc1), exp_c[1][ri1]);
                    act_c[1][ri1] = int'(rc1);
                end else chk(1'b0, "R1 extra retire", ri1, n_good);
                ri1++;
            end
        end
        chk(cyc < LIMIT, "R1 watchdog", cyc, LIMIT);
        repeat (6) begin
            @(negedge clk);
            chk(!rv0 && !rv1, "R1 no retire after last token", int'(rv0 || rv1), 0);
        end
        run = 1'b0;
    endtask

    initial begin
        // stated eight-token case
        n_tok = 8;
        for (int i = 0; i < 8; i++) begin
            t_tag[i] = 8'(i + 1);
            case (i % 4)
                0: t_cnt[i] = pk(2, 1, 1, 1);
                1: t_cnt[i] = pk(1, 3, 2, 2);
                2: t_cnt[i] = pk(2, 1, 1, 3);
                default: t_cnt[i] = pk(1, 2, 2, 2);
            endcase
        end
        run_phase("R11 R12 queued", "R12 blocking");
        chk(act_c[0][3] == 15, "R11 fourth token cycle", act_c[0][3], 15);
        chk(act_c[0][7] == 23, "R11 eighth token cycle", act_c[0][7], 23);

        // every count combination
        n_tok = 81;
        for (int i = 0; i < 81; i++) begin
            t_tag[i] = 8'(i);
            t_cnt[i] = pk(i % 3 + 1, (i / 3) % 3 + 1, (i / 9) % 3 + 1, (i / 27) % 3 + 1);
        end
        run_phase("R2 R4 sweep", "R2 R6 sweep");

        // same combinations, reversed
        for (int i = 0; i < 81; i++) begin
            t_tag[i] = 8'(200 - i);
            t_cnt[i] = pk((80 - i) % 3 + 1, ((80 - i) / 3) % 3 + 1,
                          ((80 - i) / 9) % 3 + 1, ((80 - i) / 27) % 3 + 1);
        end
        run_phase("R2 R4 reverse", "R2 R6 reverse");

        // queue fill: slow stage 2, then slow stage 4
        n_tok = 20;
        for (int i = 0; i < 20; i++) begin
            t_tag[i] = 8'(100 + i);
            t_cnt[i] = (i < 10) ? pk(1, 3, 1, 1) : pk(1, 1, 1, 3);
        end
        run_phase("R5 full queue", "R6 stalls");

        // illegal counts interleaved
        n_tok = 12;
        for (int i = 0; i < 12; i++) begin
            t_tag[i] = 8'(160 + i);
            if (i % 3 == 1) t_cnt[i] = pk((i % 4 == 0) ? 0 : 2, (i % 4 == 1) ? 0 : 1,
                                          (i % 4 == 2) ? 0 : 3, (i % 4 == 3) ? 0 : 1);
            else            t_cnt[i] = pk(i % 2 + 1, 2, 1, i % 3 + 1);
        end
        run_phase("R9 queued", "R9 blocking");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule